// File: doc/BRIEF.md
# Serial Register Access Port

This block is a serial slave that gives an external host read and write access to a bank of byte-wide registers. It uses four wires: an active-low select, a serial clock, a data-in line and a data-out line. The register storage sits outside the block. The block presents an address and write data together with a one-cycle write strobe. For reads it presents the address and a one-cycle read strobe, and it takes the byte back from a combinational read-data input.

Each transfer is sixteen serial clocks long while select is held low. The first bit gives the direction. The next bits give the register address, least significant first, and one spare bit follows that the block ignores. The last eight bits are the data byte, also least significant first. On a write the host shifts the byte in. On a read the block shifts it out. A static configuration input selects the serial clock edge on which read data is launched.

The serial pins are oversampled by the block's own clock through synchronizers. Both phases of the serial clock therefore have to last several system clocks.

Top module: `serial_reg_port`

## Requirements
- R1: While reset is low and in the first cycle after it, `sdo_oe`, `sdo`, `reg_we` and `reg_re` are all 0.
- R2: Serial input is sampled on rising serial clock edges. Bit 1 is the direction, where 0 means write. Bits 2 to 7 are the address, least significant bit first. Bits 9 to 16 are the data, least significant bit first. A write gives exactly one `reg_we` pulse, after the 16th rising edge, with `reg_addr` and `reg_wdata` valid in the same cycle.
- R3: The value of serial bit 8 has no effect on the register written or read, or on the data.
- R4: A direction bit of 1 means read. It gives exactly one `reg_re` pulse, on the 8th rising edge, and the addressed byte is sent on `sdo` in bits 9 to 16, least significant bit first.
- R5: With `clke` = 0, data bit k (k = 0 to 7) is launched on the rising edge of serial cycle 9+k. With `clke` = 1, it is launched on the falling edge that follows the rising edge of cycle 8+k. `sdo` does not change while the serial clock holds its level and select stays low.
- R6: `sdo_oe` is 0 whenever select is high, throughout the 8-bit command, and throughout a write.
- R7: Raising select before the 16th rising edge cancels the transfer with no `reg_we` pulse. The next transfer starts again from bit 1.
- R8: Rising edges after the 16th in the same transfer are ignored and cause no second strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| csn | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| clke | input | 1 | Read-data launch edge: 0 rising, 1 falling; static during a transfer |
| sdo | output | 1 | Serial read data |
| sdo_oe | output | 1 | Output enable for the `sdo` pad driver |
| reg_addr | output | ADDR_W | Register address captured from the command |
| reg_wdata | output | DATA_W | Byte captured for a write |
| reg_we | output | 1 | One-cycle write strobe |
| reg_re | output | 1 | One-cycle read strobe; `reg_rdata` is sampled in the next cycle |
| reg_rdata | input | DATA_W | Combinational read data for `reg_addr` |

## Verification
If the bit counter drifts, the write lands on the wrong address or carries shifted data. On a read, the host sees a byte rotated by one or more places, and this shows at the latest in the read-back transfer that follows. A launch on the wrong edge puts the previous bit on `sdo` for half a serial cycle, so it is caught at the first data bit the host samples. A counter that survives an aborted transfer corrupts the very next transfer. An enable that is left high is visible on `sdo_oe` a few system clocks after select rises.

// File: rtl/srp_pkg.sv
// Shared definitions for the serial register access port.
// Assumes address width >= 2 and data width >= 2.
package srp_pkg;

    // Direction encoded in the first serial bit.
    typedef enum logic {
        DIR_WRITE = 1'b0,
        DIR_READ  = 1'b1
    } srp_dir_e;

    // Total rising edges in one transfer: direction, address, spare, data.
    function automatic int frame_len(input int aw, input int dw);
        return 1 + aw + 1 + dw;
    endfunction

endpackage

// File: rtl/srp_sync.sv
// Multi-stage synchronizer bank for asynchronous serial pins.
// Each bit has its own chain and its own reset level given by RST_VAL.
// Assumes STAGES >= 2.
module srp_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [STAGES-1:0] chain;

        // Shift the pin through the chain; reset to the idle level of the pin.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
            else        chain <= {chain[STAGES-2:0], din[g]};
        end

        assign dout[g] = chain[STAGES-1];
    end

endmodule

// File: rtl/srp_frame.sv
// Transfer framing: serial clock edge detection, bit counting, command and
// write-data capture, and the register strobes.
// Assumes synchronized inputs. The counter saturates at the frame length and
// clears whenever select is inactive.
module srp_frame
    import srp_pkg::*;
#(
    parameter  int AW    = 6,
    parameter  int DW    = 8,
    localparam int FRAME = frame_len(AW, DW),
    localparam int CW    = $clog2(FRAME + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          csn_s,
    input  logic          sclk_s,
    input  logic          sdi_s,
    output logic          cs_act,
    output logic          sclk_rise,
    output logic          sclk_fall,
    output logic [CW-1:0] bit_cnt,
    output logic          dir_rd,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] wdata_q,
    output logic          we_q,
    output logic          re_q
);

    localparam logic [CW-1:0] CNT_LAST  = CW'(FRAME - 1);
    localparam logic [CW-1:0] CNT_FULL  = CW'(FRAME);
    localparam logic [CW-1:0] CNT_ADDRN = CW'(AW);
    localparam logic [CW-1:0] CNT_SPARE = CW'(AW + 1);

    logic sclk_d;

    // Select is active low; edges only count while selected.
    assign cs_act    = ~csn_s;
    assign sclk_rise = cs_act &  sclk_s & ~sclk_d;
    assign sclk_fall = cs_act & ~sclk_s &  sclk_d;

    // Remember the previous serial clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s;
    end

    // Count rising edges and capture each field in its slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            dir_rd  <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            we_q    <= 1'b0;
            re_q    <= 1'b0;
        end else begin
            we_q <= 1'b0;
            re_q <= 1'b0;
            if (!cs_act) begin
                bit_cnt <= '0;
            end else if (sclk_rise && bit_cnt < CNT_FULL) begin
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == '0) begin
                    dir_rd <= (sdi_s == DIR_READ);
                end else if (bit_cnt <= CNT_ADDRN) begin
                    addr_q <= {sdi_s, addr_q[AW-1:1]};
                end else if (bit_cnt == CNT_SPARE) begin
                    re_q <= dir_rd;
                end else begin
                    wdata_q <= {sdi_s, wdata_q[DW-1:1]};
                    if (bit_cnt == CNT_LAST) we_q <= ~dir_rd;
                end
            end
        end
    end

endmodule

// File: rtl/srp_shift.sv
// Read-data serializer and output-enable control.
// Loads the fetched byte when the read strobe fires, then launches one bit
// per selected serial edge, least significant first. clke must be static
// during a transfer.
module srp_shift
    import srp_pkg::*;
#(
    parameter  int AW    = 6,
    parameter  int DW    = 8,
    localparam int FRAME = frame_len(AW, DW),
    localparam int CW    = $clog2(FRAME + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_act,
    input  logic          sclk_rise,
    input  logic          sclk_fall,
    input  logic [CW-1:0] bit_cnt,
    input  logic          dir_rd,
    input  logic          clke,
    input  logic          load,
    input  logic [DW-1:0] rdata,
    output logic          sdo,
    output logic          sdo_oe
);

    localparam logic [CW-1:0] CNT_DATA0 = CW'(AW + 2);
    localparam logic [CW-1:0] CNT_FULL  = CW'(FRAME);

    logic [DW-1:0] sh_q;
    logic          in_window;
    logic          launch;

    // Launches are allowed only during the data phase of a read.
    assign in_window = dir_rd && (bit_cnt >= CNT_DATA0) && (bit_cnt < CNT_FULL);
    assign launch    = in_window && (clke ? sclk_fall : sclk_rise);

    // Load, shift and drive; everything is released when select goes inactive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            sdo    <= 1'b0;
            sdo_oe <= 1'b0;
        end else if (!cs_act) begin
            sdo    <= 1'b0;
            sdo_oe <= 1'b0;
        end else if (load) begin
            sh_q <= rdata;
        end else if (launch) begin
            sdo    <= sh_q[0];
            sh_q   <= sh_q >> 1;
            sdo_oe <= 1'b1;
        end
    end

endmodule

// File: rtl/serial_reg_port.sv
// Top level of the serial register access port.
// Synchronizes the four-wire serial interface into clk, frames transfers
// and drives strobes toward an external register bank.
// Assumes each serial clock phase spans at least SYNC_STAGES + 2 clk cycles,
// and that reg_rdata is a combinational function of reg_addr.
module serial_reg_port
    import srp_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csn,
    input  logic              sclk,
    input  logic              sdi,
    input  logic              clke,
    output logic              sdo,
    output logic              sdo_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              reg_re,
    input  logic [DATA_W-1:0] reg_rdata
);

    localparam int FRAME = frame_len(ADDR_W, DATA_W);
    localparam int CW    = $clog2(FRAME + 1);

    logic [2:0]    pins_s;
    logic          cs_act;
    logic          sclk_rise;
    logic          sclk_fall;
    logic [CW-1:0] bit_cnt;
    logic          dir_rd;

    // Pin order {sdi, sclk, csn}; select idles high.
    srp_sync #(
        .W      (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b001)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({sdi, sclk, csn}),
        .dout (pins_s)
    );

    srp_frame #(
        .AW(ADDR_W),
        .DW(DATA_W)
    ) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .csn_s    (pins_s[0]),
        .sclk_s   (pins_s[1]),
        .sdi_s    (pins_s[2]),
        .cs_act   (cs_act),
        .sclk_rise(sclk_rise),
        .sclk_fall(sclk_fall),
        .bit_cnt  (bit_cnt),
        .dir_rd   (dir_rd),
        .addr_q   (reg_addr),
        .wdata_q  (reg_wdata),
        .we_q     (reg_we),
        .re_q     (reg_re)
    );

    srp_shift #(
        .AW(ADDR_W),
        .DW(DATA_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_act   (cs_act),
        .sclk_rise(sclk_rise),
        .sclk_fall(sclk_fall),
        .bit_cnt  (bit_cnt),
        .dir_rd   (dir_rd),
        .clke     (clke),
        .load     (reg_re),
        .rdata    (reg_rdata),
        .sdo      (sdo),
        .sdo_oe   (sdo_oe)
    );

endmodule

// File: rtl/srp_checker.sv
// Protocol checker for serial_reg_port, attached by bind.
// Observes strobes, output enable and the framing state.
module srp_checker
    import srp_pkg::*;
#(
    parameter  int AW    = 6,
    parameter  int DW    = 8,
    localparam int FRAME = frame_len(AW, DW),
    localparam int CW    = $clog2(FRAME + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_act,
    input logic          sclk_rise,
    input logic          sclk_fall,
    input logic [CW-1:0] bit_cnt,
    input logic          reg_we,
    input logic          reg_re,
    input logic          sdo,
    input logic          sdo_oe
);

    // R1: outputs idle during and right after reset
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!reg_we && !reg_re && !sdo_oe && !sdo));

    // R2: write strobe lasts one cycle
    a_r2_we_single: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R7: a write only after a complete frame
    a_r7_we_full_frame: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (bit_cnt == CW'(FRAME)));

    // R4: read strobe is single and tied to the spare-bit edge
    a_r4_re_single: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |=> !reg_re);
    a_r4_re_at_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |-> (bit_cnt == CW'(AW + 2)));

    // R6: no drive while deselected or during the command
    a_r6_off_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !sdo_oe);
    a_r6_off_command: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_cnt < CW'(AW + 2)) |=> !sdo_oe);

    // R5: output holds while the serial clock holds its level
    a_r5_sdo_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_act && !sclk_rise && !sclk_fall) |=> $stable(sdo));

endmodule

bind serial_reg_port srp_checker #(
    .AW(ADDR_W),
    .DW(DATA_W)
) u_srp_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_act   (cs_act),
    .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall),
    .bit_cnt  (bit_cnt),
    .reg_we   (reg_we),
    .reg_re   (reg_re),
    .sdo      (sdo),
    .sdo_oe   (sdo_oe)
);

// File: tb/serial_reg_port_bench.sv
// Directed bench: a host model bit-bangs transfers and a behavioural
// register bank answers the strobes.
module serial_reg_port_bench;

    localparam int HALF = 8;   // clk cycles per serial clock phase

    logic clk = 1'b0;
    always #10 clk = ~clk;     // 50 MHz

    logic       rst_n = 1'b0;
    logic       csn   = 1'b1;
    logic       sclk  = 1'b0;
    logic       sdi   = 1'b0;
    logic       clke  = 1'b0;
    logic       sdo, sdo_oe, reg_we, reg_re;
    logic [5:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;

    logic [7:0] mem [64];
    int we_cnt = 0;
    int re_cnt = 0;
    int n_chk  = 0;
    int n_fail = 0;

    serial_reg_port u_serial_reg_port (
        .clk(clk), .rst_n(rst_n), .csn(csn), .sclk(sclk), .sdi(sdi),
        .clke(clke), .sdo(sdo), .sdo_oe(sdo_oe), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re),
        .reg_rdata(reg_rdata)
    );

    // Behavioural register bank.
    assign reg_rdata = mem[reg_addr];
    always @(posedge clk) begin
        if (reg_we) begin
            mem[reg_addr] <= reg_wdata;
            we_cnt <= we_cnt + 1;
        end
        if (reg_re) re_cnt <= re_cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // One host transfer of nrise rising edges; d is the write byte or expected read byte.
    task automatic xfer(input bit rd, input logic [5:0] a, input bit spare,
                        input logic [7:0] d, input bit ck, input int nrise,
                        output logic [7:0] got);
        logic [15:0] bits;
        bits = {d, spare, a, rd};
        got  = '0;
        clke = ck;
        @(negedge clk);
        csn = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nrise; i++) begin
            sdi = (i < 16) ? bits[i] : 1'b0;
            repeat (HALF) @(negedge clk);
            if (i < 8 || !rd) begin
                chk(sdo_oe == 1'b0, "R6", sdo_oe, 0);
            end else if (i < 16) begin
                if (ck) begin
                    chk(sdo_oe == 1'b1, "R5", sdo_oe, 1);
                    chk(sdo == d[i-8], "R5", sdo, d[i-8]);
                end else if (i >= 9) begin
                    chk(sdo == d[i-9], "R5", sdo, d[i-9]);
                end
            end
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            if (i < 8 || !rd) begin
                chk(sdo_oe == 1'b0, "R6", sdo_oe, 0);
            end else if (i < 16) begin
                chk(sdo_oe == 1'b1, "R4", sdo_oe, 1);
                got[i-8] = sdo;
            end
            sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        csn = 1'b1;
        repeat (12) @(negedge clk);
        chk(sdo_oe == 1'b0, "R6", sdo_oe, 0);
    endtask

    task automatic do_write(input logic [5:0] a, input logic [7:0] d, input bit spare);
        logic [7:0] unused;
        xfer(1'b0, a, spare, d, 1'b0, 16, unused);
    endtask

    task automatic do_read(input logic [5:0] a, input logic [7:0] exp, input bit ck,
                           input bit spare, input string req);
        logic [7:0] got;
        int re0;
        re0 = re_cnt;
        xfer(1'b1, a, spare, exp, ck, 16, got);
        chk(got == exp, req, got, exp);
        chk(re_cnt == re0 + 1, "R4", re_cnt - re0, 1);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(!sdo_oe && !reg_we && !reg_re && !sdo, "R1", {sdo_oe, reg_we, reg_re, sdo}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!sdo_oe && !reg_we && !reg_re && !sdo, "R1", {sdo_oe, reg_we, reg_re, sdo}, 0);
        repeat (4) @(negedge clk);
    endtask

    task automatic t_write_read();
        int w0;
        w0 = we_cnt;
        do_write(6'h2A, 8'hC5, 1'b0);
        chk(we_cnt == w0 + 1, "R2", we_cnt - w0, 1);
        chk(mem[6'h2A] == 8'hC5, "R2", mem[6'h2A], 8'hC5);
        do_read(6'h2A, 8'hC5, 1'b1, 1'b0, "R4");
        do_read(6'h2A, 8'hC5, 1'b0, 1'b0, "R5");
    endtask

    task automatic t_addr_order();
        do_write(6'h01, 8'h11, 1'b0);
        do_write(6'h20, 8'h80, 1'b0);
        chk(mem[6'h01] == 8'h11, "R2", mem[6'h01], 8'h11);
        chk(mem[6'h20] == 8'h80, "R2", mem[6'h20], 8'h80);
        do_read(6'h20, 8'h80, 1'b0, 1'b0, "R4");
        do_read(6'h01, 8'h11, 1'b1, 1'b0, "R4");
    endtask

    task automatic t_spare_bit();
        do_write(6'h15, 8'h3C, 1'b1);
        chk(mem[6'h15] == 8'h3C, "R3", mem[6'h15], 8'h3C);
        do_read(6'h15, 8'h3C, 1'b1, 1'b1, "R3");
    endtask

    task automatic t_abort();
        logic [7:0] unused;
        int w0;
        w0 = we_cnt;
        xfer(1'b0, 6'h2A, 1'b0, 8'hFF, 1'b0, 12, unused);
        chk(we_cnt == w0, "R7", we_cnt - w0, 0);
        chk(mem[6'h2A] == 8'hC5, "R7", mem[6'h2A], 8'hC5);
        do_read(6'h2A, 8'hC5, 1'b1, 1'b0, "R7");
    endtask

    task automatic t_overrun();
        logic [7:0] unused;
        int w0;
        w0 = we_cnt;
        xfer(1'b0, 6'h33, 1'b0, 8'h5A, 1'b0, 20, unused);
        chk(we_cnt == w0 + 1, "R8", we_cnt - w0, 1);
        chk(mem[6'h33] == 8'h5A, "R8", mem[6'h33], 8'h5A);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 8'h00;
    end

    initial begin
        t_reset();
        t_write_read();
        t_addr_order();
        t_spare_bit();
        t_abort();
        t_overrun();
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

endmodule